// File: doc/BRIEF.md
# Tape Link Host Sequencer

This block runs the host side of a packet protocol spoken by a serial cassette tape drive over a byte-wide UART. After reset it wakes the drive up. It holds a line break while two zero bytes go out, then drops the break and sends two INIT flag bytes. It then waits for the drive to answer with a CONTINUE byte. Once the link is up, the block accepts one transfer request at a time. A request carries the direction, a verify option, the drive unit, a block number and a byte count. The block turns the request into a fourteen-byte command packet. For reads, it then hands the line to an external packet receiver and waits for that receiver to report the end packet.

For writes, the drive paces the host. Each data packet may only start after a CONTINUE byte arrives. A data packet is a data flag, a length of at most 128, that many bytes fetched from a buffer read port, and a two-byte checksum. The checksum is computed outside the block and presented on `sum_in`. When no bytes remain, the receiver takes over to collect the end packet. A command flag from the drive while the block waits means the drive ended early, and the receiver takes over at once. An INIT byte or any unexpected byte aborts the request and restarts the wake-up sequence.

States and transitions:
- `ST_BREAK` → `ST_INITF`: after the two zero bytes.
- `ST_INITF` → `ST_INITW`: after the two INIT bytes.
- `ST_INITW` → `ST_IDLE`: on CONTINUE.
- `ST_INITW` → `ST_BREAK`: on any other byte or on a stall.
- `ST_IDLE` → `ST_CMD`: on a legal request.
- `ST_IDLE` stays put when a request is rejected.
- `ST_CMD` → `ST_RECV`: for a read or a zero-length write.
- `ST_CMD` → `ST_WWAIT`: for a write with bytes to send.
- `ST_WWAIT` → `ST_DHDR`: on CONTINUE.
- `ST_WWAIT` → `ST_RECV`: on a command flag.
- `ST_WWAIT` → `ST_BREAK`: on any other byte.
- `ST_DHDR` → `ST_DDAT` → `ST_DCHK`: as each part of a data packet goes out.
- `ST_DCHK` → `ST_WWAIT` or `ST_RECV`: by whether bytes remain.
- `ST_RECV` → `ST_IDLE`: on receiver finish.
- `ST_WWAIT` or `ST_RECV` → `ST_CMD`: on a first stall (retry).
- `ST_WWAIT` or `ST_RECV` → `ST_IDLE`: on a second stall (failure).

Top module: `tape_host_seq`

## Requirements
- R1: After reset the block asserts `tx_break` and sends two 0x00 bytes. It then deasserts `tx_break` and sends two 0x04 (INIT) bytes. `req_ready` stays low throughout.
- R2: While waiting after the INIT bytes, a received 0x10 (CONTINUE) raises `req_ready`. Any other received byte restarts the R1 sequence.
- R3: An accepted request sends 14 bytes in this order: 0x02, 0x0A, opcode (read 0x02, write 0x03), modifier, unit, 0x00, 0x00, 0x00, count low, count high, block low, block high, `sum_in` low, `sum_in` high.
- R4: The modifier byte is 0x01 for a write with `req_verify` set. It is 0x00 for reads and for writes without verify.
- R5: After a read command, or after the last data packet of a write, `recv_en` is high. A `recv_fin` pulse then gives one `done` pulse with `error` equal to `recv_fail`, and `req_ready` returns high.
- R6: A write sends nothing after its command until a 0x10 byte arrives. It then sends one data packet: 0x01, the length min(128, remaining), that many bytes read from buffer addresses counting up from 0 across packets, then `sum_in` low and high.
- R7: After each data packet the remaining count drops by its length. If bytes remain, the block waits for 0x10 again. Otherwise `recv_en` goes high.
- R8: While a write waits for 0x10, a received 0x02 raises `recv_en` at once. A received 0x04 or any other byte gives `done` with `error` and restarts the R1 sequence.
- R9: A request with block number 512 or above gives `done` with `error` one cycle after acceptance. No byte is sent.
- R10: While a request waits for the drive, 40 `tick` pulses with no received byte re-send the command and restart the transfer from buffer address 0. A second such stall in the same request gives `done` with `error` and returns to idle.
- R11: A byte offered with `tx_valid` while `tx_ready` is low is held unchanged. `error` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Stall-timer tick pulse |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_verify | input | 1 | Write with read-back verify |
| req_unit | input | 8 | Drive unit number |
| req_block | input | 16 | Block number |
| req_count | input | 16 | Byte count |
| tx_data | output | 8 | Byte to transmitter |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| tx_break | output | 1 | Hold line break |
| rx_byte | input | 8 | Byte from receiver |
| rx_strobe | input | 1 | `rx_byte` valid (one cycle) |
| buf_addr | output | 16 | Write-data buffer address |
| buf_rdata | input | 8 | Buffer data, same-cycle read |
| sum_in | input | 16 | Packet checksum from the external summing unit |
| recv_en | output | 1 | Packet receiver owns the line |
| recv_fin | input | 1 | Receiver got the end packet |
| recv_fail | input | 1 | End packet reported a failure |
| done | output | 1 | Request finished (one-cycle pulse) |
| error | output | 1 | Request failed, valid with `done` |

## Verification
The assertions assume the following about the inputs:
- `rx_strobe` and `recv_fin` are single-cycle pulses, and `recv_fin` arrives only while `recv_en` is high.
- `buf_rdata` is a pure function of `buf_addr`.
- `sum_in` does not move while a checksum byte waits for `tx_ready`. Without this, the hold check on `tx_data` could fire on a correct design.

The stimulus keeps within these limits. The modelled buffer is a fixed arithmetic function of the address. The checksum input is held constant. Drive responses are sent only after every expected byte has left, and `tx_ready` is dropped every fifth cycle so that the hold rule is exercised.

// File: rtl/tape_seq_pkg.sv
package tape_seq_pkg;

    localparam int FIELD_W   = 16;
    localparam int CMD_BYTES = 14;

    localparam logic [7:0] FLG_DATA    = 8'h01;
    localparam logic [7:0] FLG_CMD     = 8'h02;
    localparam logic [7:0] FLG_INIT    = 8'h04;
    localparam logic [7:0] FLG_CONT    = 8'h10;
    localparam logic [7:0] OPC_READ    = 8'h02;
    localparam logic [7:0] OPC_WRITE   = 8'h03;
    localparam logic [7:0] CMD_MSG_LEN = 8'd10;
    localparam logic [7:0] MOD_VERIFY  = 8'h01;

    typedef enum logic [3:0] {
        ST_BREAK,
        ST_INITF,
        ST_INITW,
        ST_IDLE,
        ST_CMD,
        ST_WWAIT,
        ST_DHDR,
        ST_DDAT,
        ST_DCHK,
        ST_RECV
    } seq_state_e;

endpackage

// File: rtl/tape_cmd_fmt.sv
module tape_cmd_fmt
    import tape_seq_pkg::*;
(
    input  logic [3:0]         idx,
    input  logic [7:0]         opcode,
    input  logic [7:0]         modifier,
    input  logic [7:0]         unit,
    input  logic [FIELD_W-1:0] count,
    input  logic [FIELD_W-1:0] block,
    input  logic [FIELD_W-1:0] sum,
    output logic [7:0]         pkt_byte
);

    logic [7:0] frame [CMD_BYTES];

    // Byte order on the line; multi-byte fields low byte first.
    assign frame[0]  = FLG_CMD;
    assign frame[1]  = CMD_MSG_LEN;
    assign frame[2]  = opcode;
    assign frame[3]  = modifier;
    assign frame[4]  = unit;
    assign frame[5]  = 8'h00;          // switches
    assign frame[6]  = 8'h00;          // sequence low
    assign frame[7]  = 8'h00;          // sequence high
    assign frame[8]  = count[7:0];
    assign frame[9]  = count[15:8];
    assign frame[10] = block[7:0];
    assign frame[11] = block[15:8];
    assign frame[12] = sum[7:0];
    assign frame[13] = sum[15:8];

    always_comb begin
        pkt_byte = 8'h00;
        if (int'(idx) < CMD_BYTES) begin
            pkt_byte = frame[idx];
        end
    end

endmodule

// File: rtl/tape_chunk_ctr.sv
module tape_chunk_ctr #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    parameter int CHUNK  = 128,
    parameter int LEN_W  = $clog2(CHUNK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              open,
    input  logic              step,
    input  logic              close,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len,
    output logic              last_byte,
    output logic              last_chunk
);

    localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK);

    logic [CNT_W-1:0] rem;
    logic [LEN_W-1:0] left;
    logic [LEN_W-1:0] len_next;

    assign len_next   = (rem >= CHUNK_C) ? LEN_W'(CHUNK) : LEN_W'(rem);
    assign last_byte  = (left == LEN_W'(1));
    assign last_chunk = (rem == CNT_W'(len));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            addr <= '0;
            len  <= '0;
            left <= '0;
        end else if (load) begin
            rem  <= load_count;
            addr <= '0;
        end else begin
            if (open) begin
                len  <= len_next;
                left <= len_next;
            end
            if (step) begin
                addr <= addr + ADDR_W'(1);
                left <= left - LEN_W'(1);
            end
            if (close) begin
                rem <= rem - CNT_W'(len);
            end
        end
    end

endmodule

// File: rtl/tape_stall_timer.sv
module tape_stall_timer #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic tick,
    output logic hit
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign hit = run && !clear && tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clear || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/tape_host_seq.sv
module tape_host_seq
    import tape_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int MAX_BLOCKS  = 512,
    parameter int CHUNK       = 128,
    parameter int STALL_TICKS = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_verify,
    input  logic [7:0]         req_unit,
    input  logic [FIELD_W-1:0] req_block,
    input  logic [FIELD_W-1:0] req_count,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_break,
    input  logic [7:0]         rx_byte,
    input  logic               rx_strobe,
    output logic [ADDR_W-1:0]  buf_addr,
    input  logic [7:0]         buf_rdata,
    input  logic [FIELD_W-1:0] sum_in,
    output logic               recv_en,
    input  logic               recv_fin,
    input  logic               recv_fail,
    output logic               done,
    output logic               error
);

    localparam int LEN_W = $clog2(CHUNK + 1);
    localparam logic [FIELD_W-1:0] BLK_LIMIT = FIELD_W'(MAX_BLOCKS);
    localparam logic [3:0] CMD_LAST = 4'(CMD_BYTES - 1);

    seq_state_e state, state_n;
    logic [3:0] idx, idx_n;

    logic               r_write;
    logic [7:0]         r_mod;
    logic [7:0]         r_unit;
    logic [FIELD_W-1:0] r_block;
    logic [FIELD_W-1:0] r_count;
    logic               retried;

    logic load_req, ld_chunk, open_chunk, step_chunk, close_chunk;
    logic retry_set, done_n, err_n;
    logic tx_fire, pair_end, stall_hit, waiting;

    logic [LEN_W-1:0] chunk_len;
    logic             chunk_last_byte, chunk_last;
    logic [7:0]       cmd_byte;

    assign tx_fire  = tx_valid && tx_ready;
    assign pair_end = (idx == 4'd1);
    assign waiting  = (state == ST_INITW) || (state == ST_WWAIT) || (state == ST_RECV);

    tape_cmd_fmt u_fmt (
        .idx      (idx),
        .opcode   (r_write ? OPC_WRITE : OPC_READ),
        .modifier (r_mod),
        .unit     (r_unit),
        .count    (r_count),
        .block    (r_block),
        .sum      (sum_in),
        .pkt_byte (cmd_byte)
    );

    tape_chunk_ctr #(
        .CNT_W  (FIELD_W),
        .ADDR_W (ADDR_W),
        .CHUNK  (CHUNK),
        .LEN_W  (LEN_W)
    ) u_chunk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld_chunk),
        .load_count ((state == ST_IDLE) ? req_count : r_count),
        .open       (open_chunk),
        .step       (step_chunk),
        .close      (close_chunk),
        .addr       (buf_addr),
        .len        (chunk_len),
        .last_byte  (chunk_last_byte),
        .last_chunk (chunk_last)
    );

    tape_stall_timer #(
        .LIMIT (STALL_TICKS)
    ) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (waiting),
        .clear (rx_strobe),
        .tick  (tick),
        .hit   (stall_hit)
    );

    // Next state and datapath control
    always_comb begin
        state_n     = state;
        idx_n       = idx;
        load_req    = 1'b0;
        ld_chunk    = 1'b0;
        open_chunk  = 1'b0;
        step_chunk  = 1'b0;
        close_chunk = 1'b0;
        retry_set   = 1'b0;
        done_n      = 1'b0;
        err_n       = 1'b0;
        unique case (state)
            ST_BREAK: begin
                if (tx_fire) begin
                    if (pair_end) begin
                        state_n = ST_INITF;
                        idx_n   = '0;
                    end else begin
                        idx_n = idx + 4'd1;
                    end
                end
            end
            ST_INITF: begin
                if (tx_fire) begin
                    if (pair_end) begin
                        state_n = ST_INITW;
                        idx_n   = '0;
                    end else begin
                        idx_n = idx + 4'd1;
                    end
                end
            end
            ST_INITW: begin
                if (rx_strobe) begin
                    state_n = (rx_byte == FLG_CONT) ? ST_IDLE : ST_BREAK;
                    idx_n   = '0;
                end else if (stall_hit) begin
                    state_n = ST_BREAK;
                    idx_n   = '0;
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_block >= BLK_LIMIT) begin
                        done_n = 1'b1;
                        err_n  = 1'b1;
                    end else begin
                        load_req = 1'b1;
                        ld_chunk = 1'b1;
                        state_n  = ST_CMD;
                        idx_n    = '0;
                    end
                end
            end
            ST_CMD: begin
                if (tx_fire) begin
                    if (idx == CMD_LAST) begin
                        idx_n   = '0;
                        state_n = (r_write && (r_count != '0)) ? ST_WWAIT : ST_RECV;
                    end else begin
                        idx_n = idx + 4'd1;
                    end
                end
            end
            ST_WWAIT: begin
                if (rx_strobe) begin
                    idx_n = '0;
                    if (rx_byte == FLG_CONT) begin
                        open_chunk = 1'b1;
                        state_n    = ST_DHDR;
                    end else if (rx_byte == FLG_CMD) begin
                        state_n = ST_RECV;
                    end else begin
                        done_n  = 1'b1;
                        err_n   = 1'b1;
                        state_n = ST_BREAK;
                    end
                end else if (stall_hit) begin
                    idx_n = '0;
                    if (!retried) begin
                        retry_set = 1'b1;
                        ld_chunk  = 1'b1;
                        state_n   = ST_CMD;
                    end else begin
                        done_n  = 1'b1;
                        err_n   = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_DHDR: begin
                if (tx_fire) begin
                    if (pair_end) begin
                        state_n = ST_DDAT;
                        idx_n   = '0;
                    end else begin
                        idx_n = idx + 4'd1;
                    end
                end
            end
            ST_DDAT: begin
                if (tx_fire) begin
                    step_chunk = 1'b1;
                    if (chunk_last_byte) begin
                        state_n = ST_DCHK;
                    end
                end
            end
            ST_DCHK: begin
                if (tx_fire) begin
                    if (pair_end) begin
                        close_chunk = 1'b1;
                        idx_n       = '0;
                        state_n     = chunk_last ? ST_RECV : ST_WWAIT;
                    end else begin
                        idx_n = idx + 4'd1;
                    end
                end
            end
            ST_RECV: begin
                if (recv_fin) begin
                    done_n  = 1'b1;
                    err_n   = recv_fail;
                    state_n = ST_IDLE;
                end else if (stall_hit) begin
                    idx_n = '0;
                    if (!retried) begin
                        retry_set = 1'b1;
                        ld_chunk  = 1'b1;
                        state_n   = ST_CMD;
                    end else begin
                        done_n  = 1'b1;
                        err_n   = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
            end
            default: begin
                state_n = ST_BREAK;
                idx_n   = '0;
            end
        endcase
    end

    // Line-side outputs
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        tx_break  = 1'b0;
        req_ready = 1'b0;
        recv_en   = 1'b0;
        unique case (state)
            ST_BREAK: begin
                tx_valid = 1'b1;
                tx_break = 1'b1;
            end
            ST_INITF: begin
                tx_valid = 1'b1;
                tx_data  = FLG_INIT;
            end
            ST_INITW, ST_WWAIT: begin
            end
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_CMD: begin
                tx_valid = 1'b1;
                tx_data  = cmd_byte;
            end
            ST_DHDR: begin
                tx_valid = 1'b1;
                tx_data  = (idx == 4'd0) ? FLG_DATA : 8'(chunk_len);
            end
            ST_DDAT: begin
                tx_valid = 1'b1;
                tx_data  = buf_rdata;
            end
            ST_DCHK: begin
                tx_valid = 1'b1;
                tx_data  = (idx == 4'd0) ? sum_in[7:0] : sum_in[15:8];
            end
            ST_RECV: begin
                recv_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_BREAK;
            idx     <= '0;
            r_write <= 1'b0;
            r_mod   <= '0;
            r_unit  <= '0;
            r_block <= '0;
            r_count <= '0;
            retried <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            done  <= done_n;
            error <= err_n;
            if (load_req) begin
                r_write <= req_write;
                r_mod   <= (req_write && req_verify) ? MOD_VERIFY : 8'h00;
                r_unit  <= req_unit;
                r_block <= req_block;
                r_count <= req_count;
                retried <= 1'b0;
            end else if (retry_set) begin
                retried <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tape_host_seq_chk.sv
module tape_host_seq_chk #(
    parameter int MAX_BLOCKS = 512
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_block,
    input logic [7:0]  tx_data,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        tx_break,
    input logic        recv_en,
    input logic        recv_fin,
    input logic        recv_fail,
    input logic        done,
    input logic        error
);

    // R1
    break_nulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_break) |-> (tx_data == 8'h00));

    // R9
    block_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_block >= 16'(MAX_BLOCKS))) |=> (done && error));

    // R5
    recv_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recv_en && recv_fin) |=> (done && (error == $past(recv_fail))));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_break)));

    // R11
    error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R5
    recv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recv_en |-> (!tx_valid && !req_ready));

endmodule

bind tape_host_seq tape_host_seq_chk #(.MAX_BLOCKS(MAX_BLOCKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_block (req_block),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_break  (tx_break),
    .recv_en   (recv_en),
    .recv_fin  (recv_fin),
    .recv_fail (recv_fail),
    .done      (done),
    .error     (error)
);

// File: tb/tape_host_seq_tb.sv
`timescale 1ns/1ps
module tape_host_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_verify = 1'b0;
    logic [7:0]  req_unit = '0;
    logic [15:0] req_block = '0;
    logic [15:0] req_count = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        tx_break;
    logic [7:0]  rx_byte = '0;
    logic        rx_strobe = 1'b0;
    logic [15:0] buf_addr;
    logic [7:0]  buf_rdata;
    logic [15:0] sum_in = 16'hC3A5;
    logic        recv_en;
    logic        recv_fin = 1'b0;
    logic        recv_fail = 1'b0;
    logic        done;
    logic        error;

    always #2.5 clk = ~clk;

    tape_host_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_verify(req_verify), .req_unit(req_unit), .req_block(req_block),
        .req_count(req_count), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_break(tx_break), .rx_byte(rx_byte),
        .rx_strobe(rx_strobe), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .sum_in(sum_in), .recv_en(recv_en), .recv_fin(recv_fin),
        .recv_fail(recv_fail), .done(done), .error(error)
    );

    int total = 0;
    int bad   = 0;

    logic [8:0] exp_q [$];
    string      exp_tag [$];
    bit         err_q [$];
    string      err_tag [$];

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        return 8'(a * 16'd37 + 16'd11);
    endfunction

    assign buf_rdata = mem_at(buf_addr);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected line bytes and completions.
    initial begin : monitor
        int cyc;
        logic [8:0] e;
        string t;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = (cyc % 5) != 3;
            #1;
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected byte", {tx_break, tx_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    chk({tx_break, tx_data} == e, t, {tx_break, tx_data}, e);
                end
            end
            if (rst_n && done) begin
                if (err_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", error, 0);
                end else begin
                    t = err_tag.pop_front();
                    chk(error == err_q.pop_front(), t, error, !error);
                end
            end
        end
    end

    initial begin : ticker
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic push_b(input bit brk, input logic [7:0] b, input string tag);
        exp_q.push_back({brk, b});
        exp_tag.push_back(tag);
    endtask

    task automatic push_init();
        push_b(1'b1, 8'h00, "R1 break null");
        push_b(1'b1, 8'h00, "R1 break null");
        push_b(1'b0, 8'h04, "R1 init flag");
        push_b(1'b0, 8'h04, "R1 init flag");
    endtask

    task automatic push_cmd(input logic [7:0] op, input logic [7:0] md, input logic [7:0] un,
                            input logic [15:0] cnt, input logic [15:0] blk);
        push_b(1'b0, 8'h02, "R3 flag");
        push_b(1'b0, 8'h0A, "R3 msg count");
        push_b(1'b0, op, "R3 opcode");
        push_b(1'b0, md, "R4 modifier");
        push_b(1'b0, un, "R3 unit");
        push_b(1'b0, 8'h00, "R3 switches");
        push_b(1'b0, 8'h00, "R3 seq lo");
        push_b(1'b0, 8'h00, "R3 seq hi");
        push_b(1'b0, cnt[7:0], "R3 count lo");
        push_b(1'b0, cnt[15:8], "R3 count hi");
        push_b(1'b0, blk[7:0], "R3 block lo");
        push_b(1'b0, blk[15:8], "R3 block hi");
        push_b(1'b0, sum_in[7:0], "R3 sum lo");
        push_b(1'b0, sum_in[15:8], "R3 sum hi");
    endtask

    task automatic push_data(input int start, input int len);
        push_b(1'b0, 8'h01, "R6 data flag");
        push_b(1'b0, 8'(len), "R6 data length");
        for (int i = 0; i < len; i++) begin
            push_b(1'b0, mem_at(16'(start + i)), "R6 data byte");
        end
        push_b(1'b0, sum_in[7:0], "R6 sum lo");
        push_b(1'b0, sum_in[15:8], "R6 sum hi");
    endtask

    task automatic push_done(input bit e, input string tag);
        err_q.push_back(e);
        err_tag.push_back(tag);
    endtask

    task automatic drain();
        do begin
            @(negedge clk);
            #2;
        end while (exp_q.size() != 0);
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (err_q.size() != 0 && n < 3000) begin
            @(negedge clk);
            #2;
            n++;
        end
        chk(err_q.size() == 0, tag, err_q.size(), 0);
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk);
        rx_byte   = b;
        rx_strobe = 1'b1;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic finish_recv(input bit fail);
        @(negedge clk);
        recv_fin  = 1'b1;
        recv_fail = fail;
        @(negedge clk);
        recv_fin  = 1'b0;
        recv_fail = 1'b0;
    endtask

    task automatic send_req(input bit wr, input bit vf, input logic [7:0] un,
                            input logic [15:0] blk, input logic [15:0] cnt);
        do @(negedge clk); while (!req_ready);
        req_write  = wr;
        req_verify = vf;
        req_unit   = un;
        req_block  = blk;
        req_count  = cnt;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    initial begin : main
        push_init();
        repeat (4) @(negedge clk);
        #1;
        chk(req_ready == 1'b0 && done == 1'b0, "R1 reset outputs", {req_ready, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(tx_break && tx_valid && tx_data == 8'h00, "R1 break after reset",
            {tx_break, tx_valid, tx_data}, 10'h300);

        // R2: wrong answer restarts the wake-up sequence
        drain();
        push_init();
        rx(8'h55);
        drain();
        #1;
        chk(!req_ready && !tx_valid, "R2 waiting for continue", {req_ready, tx_valid}, 0);
        rx(8'h10);
        #1;
        chk(req_ready == 1'b1, "R2 idle after continue", req_ready, 1);

        // R3 R5: read request
        push_cmd(8'h02, 8'h00, 8'h01, 16'd512, 16'd100);
        send_req(1'b0, 1'b1, 8'h01, 16'd100, 16'd512);
        drain();
        @(negedge clk);
        #1;
        chk(recv_en == 1'b1, "R5 receiver owns line after read", recv_en, 1);
        push_done(1'b0, "R5 read done ok");
        finish_recv(1'b0);
        wait_done("R5 read completion");
        #1;
        chk(req_ready == 1'b1, "R5 idle after read", req_ready, 1);

        // R9: out-of-range block
        push_done(1'b1, "R9 reject error");
        send_req(1'b0, 1'b0, 8'h00, 16'd512, 16'd16);
        wait_done("R9 reject completion");
        repeat (3) @(negedge clk);
        #1;
        chk(!tx_valid && req_ready, "R9 nothing sent", {tx_valid, req_ready}, 1);

        // R4 R6 R7: chunked verified write of 300 bytes to the last block
        push_cmd(8'h03, 8'h01, 8'h00, 16'd300, 16'd511);
        send_req(1'b1, 1'b1, 8'h00, 16'd511, 16'd300);
        drain();
        repeat (10) @(negedge clk);
        #1;
        chk(!tx_valid && !recv_en, "R6 held until continue", {tx_valid, recv_en}, 0);
        push_data(0, 128);
        rx(8'h10);
        drain();
        repeat (10) @(negedge clk);
        #1;
        chk(!tx_valid && !recv_en, "R7 waits again with bytes left", {tx_valid, recv_en}, 0);
        push_data(128, 128);
        rx(8'h10);
        drain();
        push_data(256, 44);
        rx(8'h10);
        drain();
        @(negedge clk);
        #1;
        chk(recv_en == 1'b1, "R7 receiver after last packet", recv_en, 1);
        push_done(1'b1, "R5 failing end packet");
        finish_recv(1'b1);
        wait_done("R5 write completion");

        // R4: write without verify, R8: early end packet
        push_cmd(8'h03, 8'h00, 8'h01, 16'd10, 16'd7);
        send_req(1'b1, 1'b0, 8'h01, 16'd7, 16'd10);
        drain();
        rx(8'h02);
        #1;
        chk(recv_en == 1'b1, "R8 early end to receiver", recv_en, 1);
        push_done(1'b0, "R8 early end done");
        finish_recv(1'b0);
        wait_done("R8 early end completion");

        // R8: INIT byte while waiting aborts and re-initialises
        push_cmd(8'h03, 8'h00, 8'h00, 16'd10, 16'd8);
        send_req(1'b1, 1'b0, 8'h00, 16'd8, 16'd10);
        drain();
        push_done(1'b1, "R8 init byte abort");
        push_init();
        rx(8'h04);
        drain();
        wait_done("R8 init abort completion");
        rx(8'h10);
        #1;
        chk(req_ready == 1'b1, "R8 idle after re-init", req_ready, 1);

        // R8: random byte while waiting
        push_cmd(8'h03, 8'h00, 8'h00, 16'd10, 16'd9);
        send_req(1'b1, 1'b0, 8'h00, 16'd9, 16'd10);
        drain();
        push_done(1'b1, "R8 random byte abort");
        push_init();
        rx(8'h77);
        drain();
        wait_done("R8 random abort completion");
        rx(8'h10);

        // R10: stall, one retry, then failure
        push_cmd(8'h02, 8'h00, 8'h01, 16'd64, 16'd5);
        send_req(1'b0, 1'b0, 8'h01, 16'd5, 16'd64);
        drain();
        push_cmd(8'h02, 8'h00, 8'h01, 16'd64, 16'd5);
        drain();
        push_done(1'b1, "R10 second stall fails");
        wait_done("R10 stall completion");
        #1;
        chk(req_ready == 1'b1 && !recv_en, "R10 idle after stall failure",
            {req_ready, recv_en}, 2);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R11 no leftover bytes", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule